// File: doc/BRIEF.md
# Periodic Tick and Interrupt Level Controller

This block gathers every interrupt source of a small host board onto two level-sensitive request outputs. Two programmable tick generators run from the system clock. The first is a frame tick that cannot be masked and runs at one of two slow rates. The second is a sample tick that can be switched off and runs at one of two fast rates. Each tick sets a pending flag that stays set until the host writes a dedicated clear register.

A keyboard request and nine external bus request lines also feed the block. Each of these contributes to the low-level output only when its enable bit is set. The host first reads a primary status register to learn whether the cause is the frame tick, the keyboard, the external bus or the sample tick. It then reads a second register that decodes the external line. Two of the external lines (10 and 11) share one bit of that register.

All register accesses are single-cycle strobes on a small parallel bus. Read data appears one cycle after the read strobe. The external and keyboard inputs pass through one register before they reach any status bit or output.

Top module: `irq_tick_ctrl`

## Requirements
- R1: After reset both request outputs are low and every pending flag is clear. The frame rate selects the slow rate (0), the sample tick is disabled, and the keyboard and external enables are 0.
- R2: The frame pending flag sets once every CLK_HZ/FRAME_SLOW_HZ cycles when the frame rate register (address 2, bit 0) holds 0. It sets once every CLK_HZ/FRAME_FAST_HZ cycles when that bit holds 1.
- R3: The sample pending flag sets once every CLK_HZ/SAMPLE_SLOW_HZ cycles when the sample rate register (address 3, bit 0) holds 0, or every CLK_HZ/SAMPLE_FAST_HZ cycles when it holds 1. It sets only while the sample enable (address 4, bit 0) is 1.
- R4: A write to the frame rate register restarts the frame divider from zero. A write to the sample rate or sample enable register restarts the sample divider. The next tick then comes a full period after the write.
- R5: A pending flag stays set until the host writes any value to its clear register (address 7 for frame, address 8 for sample). If a tick falls in the same cycle as the clear, the flag stays set.
- R6: No register masks the frame tick. irq_lvl2 is high in every cycle in which the frame flag is pending.
- R7: The registered keyboard request drives irq_lvl2 only while the keyboard enable (address 6, bit 0) is 1.
- R8: The OR of the registered external lines drives irq_lvl2 only while the external enable (address 5, bit 0) is 1.
- R9: The external status register (address 1) maps input lines to bits as follows: line 3 to bit 0, 4 to bit 1, 5 to bit 2, 6 to bit 3, 7 to bit 4, lines 10 and 11 (ORed) to bit 5, 14 to bit 6 and 15 to bit 7. On isa_req, index 0..8 stands for lines 3, 4, 5, 6, 7, 10, 11, 14, 15.
- R10: The primary status register (address 0) has these bits: bit 0 frame pending, bit 1 keyboard request, bit 2 any external request, bit 3 sample pending. Bits 1 and 2 ignore the enables.
- R11: Read data appears in the cycle after bus_rd and is 0 when no read is made. Reads have no side effect. The rate and enable registers read back in bit 0. The clear addresses and unused addresses read 0.
- R12: irq_lvl4 is high exactly while the sample flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after bus_rd |
| kbd_req | input | 1 | Keyboard interrupt request, level |
| isa_req | input | 9 | External request lines 3,4,5,6,7,10,11,14,15 |
| irq_lvl2 | output | 1 | Low-priority level request |
| irq_lvl4 | output | 1 | Sample tick level request |

## Verification
A divider that counts one cycle too many or too few moves the rise of a request output by one cycle. The reference model reports that on the first tick after a restart, which is at most a few thousand cycles with the bench clock rate. A lost pending flag or a wrong enable changes irq_lvl2 or irq_lvl4 in the next cycle. A status bit routed to the wrong place shows up on the first read after the input changes. The model is compared against both outputs and the read bus on every cycle, so a fault shows at its first visible cycle.

// File: rtl/irq_tick_pkg.sv
package irq_tick_pkg;

  localparam logic [3:0] A_STAT  = 4'd0;
  localparam logic [3:0] A_EXT   = 4'd1;
  localparam logic [3:0] A_FRATE = 4'd2;
  localparam logic [3:0] A_SRATE = 4'd3;
  localparam logic [3:0] A_SEN   = 4'd4;
  localparam logic [3:0] A_XEN   = 4'd5;
  localparam logic [3:0] A_KEN   = 4'd6;
  localparam logic [3:0] A_FCLR  = 4'd7;
  localparam logic [3:0] A_SCLR  = 4'd8;

  localparam int unsigned ISA_IN = 9;
  localparam int unsigned ISA_ST = 8;

  // clock cycles per tick, never below 2
  function automatic int unsigned div_cycles(int unsigned clk_hz, int unsigned rate_hz);
    int unsigned p;
    p = clk_hz / rate_hz;
    return (p < 2) ? 2 : p;
  endfunction

  // lines 10 and 11 share one status bit
  function automatic logic [ISA_ST-1:0] fold_isa(logic [ISA_IN-1:0] raw);
    return {raw[8], raw[7], raw[6] | raw[5], raw[4], raw[3], raw[2], raw[1], raw[0]};
  endfunction

endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned P_SLOW = 4,
  parameter int unsigned P_FAST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast,
  input  logic             restart,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = fast ? CNT_W'(P_FAST - 1) : CNT_W'(P_SLOW - 1);
  assign tick = run && !restart && (cnt_q == last);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart || !run)     cnt_q <= '0;
    else if (cnt_q == last)       cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/irq_isa_fold.sv
module irq_isa_fold
  import irq_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ISA_IN-1:0] raw,
  output logic [ISA_ST-1:0] folded,
  output logic              any
);

  logic [ISA_IN-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw;
  end

  assign folded = fold_isa(raw_q);
  assign any    = |folded;

endmodule

// File: rtl/irq_tick_ctrl.sv
module irq_tick_ctrl
  import irq_tick_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 40_000_000,
  parameter int unsigned FRAME_SLOW_HZ  = 50,
  parameter int unsigned FRAME_FAST_HZ  = 200,
  parameter int unsigned SAMPLE_SLOW_HZ = 10_000,
  parameter int unsigned SAMPLE_FAST_HZ = 20_000,
  parameter int unsigned ADDR_W         = 4,
  parameter int unsigned DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_req,
  input  logic [8:0]        isa_req,
  output logic              irq_lvl2,
  output logic              irq_lvl4
);

  localparam int unsigned F_SLOW_P = div_cycles(CLK_HZ, FRAME_SLOW_HZ);
  localparam int unsigned F_FAST_P = div_cycles(CLK_HZ, FRAME_FAST_HZ);
  localparam int unsigned S_SLOW_P = div_cycles(CLK_HZ, SAMPLE_SLOW_HZ);
  localparam int unsigned S_FAST_P = div_cycles(CLK_HZ, SAMPLE_FAST_HZ);
  localparam int unsigned F_CNT_W  = $clog2(F_SLOW_P + 1);
  localparam int unsigned S_CNT_W  = $clog2(S_SLOW_P + 1);

  // register state
  logic frame_fast, samp_fast, samp_en, ext_en, kbd_en;
  logic frame_pend, samp_pend, kbd_q;

  // named events
  logic                wr_frate, wr_srate, wr_sen, wr_xen, wr_ken;
  logic                frame_clr_wr, samp_clr_wr;
  logic                frame_restart, samp_restart;
  logic                frame_tick, samp_tick;
  logic [F_CNT_W-1:0]  frame_cnt;
  logic [S_CNT_W-1:0]  samp_cnt;
  logic [ISA_ST-1:0]   ext_stat;
  logic                ext_any;
  logic [DATA_W-1:0]   rd_mux;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [3:0] reg_a);
    return a == ADDR_W'(reg_a);
  endfunction

  assign wr_frate      = bus_wr && hit(bus_addr, A_FRATE);
  assign wr_srate      = bus_wr && hit(bus_addr, A_SRATE);
  assign wr_sen        = bus_wr && hit(bus_addr, A_SEN);
  assign wr_xen        = bus_wr && hit(bus_addr, A_XEN);
  assign wr_ken        = bus_wr && hit(bus_addr, A_KEN);
  assign frame_clr_wr  = bus_wr && hit(bus_addr, A_FCLR);
  assign samp_clr_wr   = bus_wr && hit(bus_addr, A_SCLR);
  assign frame_restart = wr_frate;
  assign samp_restart  = wr_srate || wr_sen;

  irq_tick_div #(
    .CNT_W (F_CNT_W),
    .P_SLOW(F_SLOW_P),
    .P_FAST(F_FAST_P)
  ) u_frame_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (1'b1),
    .fast   (frame_fast),
    .restart(frame_restart),
    .tick   (frame_tick),
    .cnt    (frame_cnt)
  );

  irq_tick_div #(
    .CNT_W (S_CNT_W),
    .P_SLOW(S_SLOW_P),
    .P_FAST(S_FAST_P)
  ) u_samp_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (samp_en),
    .fast   (samp_fast),
    .restart(samp_restart),
    .tick   (samp_tick),
    .cnt    (samp_cnt)
  );

  irq_isa_fold u_isa_fold (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (isa_req),
    .folded(ext_stat),
    .any   (ext_any)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_fast <= 1'b0;
      samp_fast  <= 1'b0;
      samp_en    <= 1'b0;
      ext_en     <= 1'b0;
      kbd_en     <= 1'b0;
      kbd_q      <= 1'b0;
    end else begin
      if (wr_frate) frame_fast <= bus_wdata[0];
      if (wr_srate) samp_fast  <= bus_wdata[0];
      if (wr_sen)   samp_en    <= bus_wdata[0];
      if (wr_xen)   ext_en     <= bus_wdata[0];
      if (wr_ken)   kbd_en     <= bus_wdata[0];
      kbd_q <= kbd_req;
    end
  end

  // sticky flags, a tick wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_pend <= 1'b0;
      samp_pend  <= 1'b0;
    end else begin
      if (frame_tick)        frame_pend <= 1'b1;
      else if (frame_clr_wr) frame_pend <= 1'b0;
      if (samp_tick)         samp_pend  <= 1'b1;
      else if (samp_clr_wr)  samp_pend  <= 1'b0;
    end
  end

  // read side
  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, A_STAT)) begin
      rd_mux[0] = frame_pend;
      rd_mux[1] = kbd_q;
      rd_mux[2] = ext_any;
      rd_mux[3] = samp_pend;
    end else if (hit(bus_addr, A_EXT)) begin
      rd_mux[ISA_ST-1:0] = ext_stat;
    end else if (hit(bus_addr, A_FRATE)) begin
      rd_mux[0] = frame_fast;
    end else if (hit(bus_addr, A_SRATE)) begin
      rd_mux[0] = samp_fast;
    end else if (hit(bus_addr, A_SEN)) begin
      rd_mux[0] = samp_en;
    end else if (hit(bus_addr, A_XEN)) begin
      rd_mux[0] = ext_en;
    end else if (hit(bus_addr, A_KEN)) begin
      rd_mux[0] = kbd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assign irq_lvl2 = frame_pend | (kbd_q & kbd_en) | (ext_any & ext_en);
  assign irq_lvl4 = samp_pend;

endmodule

// File: rtl/irq_tick_ctrl_chk.sv
module irq_tick_ctrl_chk #(
  parameter int unsigned F_CNT_W = 20,
  parameter int unsigned S_CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_tick,
  input logic               samp_tick,
  input logic               frame_pend,
  input logic               samp_pend,
  input logic               frame_clr_wr,
  input logic               samp_clr_wr,
  input logic               frame_restart,
  input logic               samp_restart,
  input logic [F_CNT_W-1:0] frame_cnt,
  input logic [S_CNT_W-1:0] samp_cnt,
  input logic               samp_en,
  input logic               kbd_en,
  input logic               ext_en,
  input logic               irq_lvl2,
  input logic               irq_lvl4
);

  // R5
  frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pend && !frame_clr_wr |=> frame_pend);

  // R5
  samp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_pend && !samp_clr_wr |=> samp_pend);

  // R2
  frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_pend) |-> $past(frame_tick));

  // R12
  samp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_pend) |-> irq_lvl4 && $past(samp_tick));

  // R3
  samp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |-> !samp_tick);

  // R4
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_restart |=> frame_cnt == '0);

  // R4
  samp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_restart |=> samp_cnt == '0);

  // R6
  frame_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pend |-> irq_lvl2);

  // R8
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl2 && !frame_pend && !kbd_en |-> ext_en);

endmodule

bind irq_tick_ctrl irq_tick_ctrl_chk #(
  .F_CNT_W(F_CNT_W),
  .S_CNT_W(S_CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_tick   (frame_tick),
  .samp_tick    (samp_tick),
  .frame_pend   (frame_pend),
  .samp_pend    (samp_pend),
  .frame_clr_wr (frame_clr_wr),
  .samp_clr_wr  (samp_clr_wr),
  .frame_restart(frame_restart),
  .samp_restart (samp_restart),
  .frame_cnt    (frame_cnt),
  .samp_cnt     (samp_cnt),
  .samp_en      (samp_en),
  .kbd_en       (kbd_en),
  .ext_en       (ext_en),
  .irq_lvl2     (irq_lvl2),
  .irq_lvl4     (irq_lvl4)
);

// File: tb/irq_tick_ctrl_bench.sv
module irq_tick_ctrl_bench;

  localparam int CLK_HZ = 200_000;
  localparam int FP_SLOW = CLK_HZ / 50;
  localparam int FP_FAST = CLK_HZ / 200;
  localparam int SP_SLOW = CLK_HZ / 10_000;
  localparam int SP_FAST = CLK_HZ / 20_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       kbd_req = 1'b0;
  logic [8:0] isa_req = '0;
  logic       irq_lvl2, irq_lvl4;

  always #10 clk = ~clk;

  irq_tick_ctrl #(.CLK_HZ(CLK_HZ)) u_irq_tick_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_req(kbd_req), .isa_req(isa_req),
    .irq_lvl2(irq_lvl2), .irq_lvl4(irq_lvl4)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_fcnt = 0, m_scnt = 0;
  bit m_ffast = 0, m_sfast = 0, m_sen = 0, m_xen = 0, m_ken = 0;
  bit m_fpend = 0, m_spend = 0, m_kq = 0;
  int m_ext = 0;
  int m_rd = 0;

  // status bit for an external line number
  function automatic int line_bit(int line);
    if (line <= 7)  return line - 3;
    if (line <= 11) return 5;
    return line - 8;
  endfunction

  function automatic int ext_of(logic [8:0] req);
    int lines[9] = '{3, 4, 5, 6, 7, 10, 11, 14, 15};
    int v = 0;
    foreach (lines[i]) if (req[i]) v |= (1 << line_bit(lines[i]));
    return v;
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return int'(m_fpend) + 2 * int'(m_kq) + 4 * int'(m_ext != 0) + 8 * int'(m_spend);
      1: return m_ext;
      2: return int'(m_ffast);
      3: return int'(m_sfast);
      4: return int'(m_sen);
      5: return int'(m_xen);
      6: return int'(m_ken);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fcnt = 0; m_scnt = 0; m_ffast = 0; m_sfast = 0; m_sen = 0;
      m_xen = 0; m_ken = 0; m_fpend = 0; m_spend = 0; m_kq = 0;
      m_ext = 0; m_rd = 0;
    end else begin
      bit ft, st;
      int fper, sper, a;
      a = int'(bus_addr);
      fper = m_ffast ? FP_FAST : FP_SLOW;
      sper = m_sfast ? SP_FAST : SP_SLOW;
      m_rd = bus_rd ? model_read(a) : 0;
      ft = 0; st = 0;
      if (bus_wr && a == 2) m_fcnt = 0;
      else if (m_fcnt == fper - 1) begin ft = 1; m_fcnt = 0; end
      else m_fcnt++;
      if (bus_wr && (a == 3 || a == 4)) m_scnt = 0;
      else if (!m_sen) m_scnt = 0;
      else if (m_scnt == sper - 1) begin st = 1; m_scnt = 0; end
      else m_scnt++;
      if (ft) m_fpend = 1; else if (bus_wr && a == 7) m_fpend = 0;
      if (st) m_spend = 1; else if (bus_wr && a == 8) m_spend = 0;
      if (bus_wr) begin
        case (a)
          2: m_ffast = bus_wdata[0];
          3: m_sfast = bus_wdata[0];
          4: m_sen   = bus_wdata[0];
          5: m_xen   = bus_wdata[0];
          6: m_ken   = bus_wdata[0];
          default: ;
        endcase
      end
      m_kq  = kbd_req;
      m_ext = ext_of(isa_req);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R6 R7 R8 model irq_lvl2", int'(irq_lvl2),
            int'(m_fpend | (m_kq & m_ken) | ((m_ext != 0) & m_xen)));
      check("R12 R3 model irq_lvl4", int'(irq_lvl4), int'(m_spend));
      check("R11 R10 R9 model read data", int'(bus_rdata), m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    bus_rd = 1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 0;
    check(tag, int'(bus_rdata), exp);
  endtask

  task automatic cycles_to_lvl2(output int n);
    n = 0;
    while (!irq_lvl2 && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic cycles_to_lvl4(output int n);
    n = 0;
    while (!irq_lvl4 && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, run did not complete");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1 lvl2 in reset", int'(irq_lvl2), 0);
    check("R1 lvl4 in reset", int'(irq_lvl4), 0);
    check("R1 rdata in reset", int'(bus_rdata), 0);
    rst_n = 1;
    cmp_on = 1;
    rd(0, 0, "R1 primary status after reset");
    rd(2, 0, "R1 frame rate slow after reset");
    rd(4, 0, "R1 sample disabled after reset");
    rd(6, 0, "R1 keyboard enable after reset");

    // R2 slow frame period measured from a restart
    wr(2, 0);
    cycles_to_lvl2(n);
    check("R2 slow frame period", n, FP_SLOW);
    rd(0, 1, "R10 frame pending in bit 0");
    rd(0, 1, "R11 second read unchanged");
    repeat (50) @(negedge clk);
    check("R5 flag held without clear", int'(irq_lvl2), 1);
    wr(7, 8'hA5);
    check("R5 frame clear drops lvl2", int'(irq_lvl2), 0);

    // R2 fast period, R4 restart mid-count
    wr(2, 1);
    cycles_to_lvl2(n);
    check("R2 fast frame period", n, FP_FAST);
    rd(2, 1, "R11 frame rate reads back");
    wr(7, 0);
    repeat (600) @(negedge clk);
    wr(2, 1);
    cycles_to_lvl2(n);
    check("R4 frame restart mid-count", n, FP_FAST);
    wr(7, 0);
    wr(2, 0);

    // R3 sample tick
    wr(3, 0);
    wr(4, 1);
    cycles_to_lvl4(n);
    check("R3 slow sample period", n, SP_SLOW);
    wr(8, 0);
    check("R5 sample clear", int'(irq_lvl4), 0);
    wr(3, 1);
    cycles_to_lvl4(n);
    check("R4 R3 fast sample after restart", n, SP_FAST);
    wr(4, 0);
    wr(8, 0);
    repeat (100) @(negedge clk);
    check("R3 disabled sample stays quiet", int'(irq_lvl4), 0);
    rd(3, 1, "R11 sample rate reads back");
    rd(8, 0, "R11 clear address reads 0");

    // R7 keyboard
    kbd_req = 1;
    repeat (2) @(negedge clk);
    check("R7 keyboard masked", int'(irq_lvl2), 0);
    rd(0, 2, "R10 R7 keyboard status bit ignores enable");
    wr(6, 1);
    check("R7 keyboard enabled", int'(irq_lvl2), 1);
    kbd_req = 0;
    repeat (2) @(negedge clk);
    check("R7 keyboard released", int'(irq_lvl2), 0);
    wr(6, 0);

    // R9 R8 external lines
    isa_req = 9'h020;
    repeat (2) @(negedge clk);
    rd(1, 8'h20, "R9 line 10 to bit 5");
    check("R8 external masked", int'(irq_lvl2), 0);
    rd(0, 4, "R10 R8 external summary ignores enable");
    isa_req = 9'h040;
    repeat (2) @(negedge clk);
    rd(1, 8'h20, "R9 line 11 shares bit 5");
    isa_req = 9'h100;
    repeat (2) @(negedge clk);
    rd(1, 8'h80, "R9 line 15 to bit 7");
    isa_req = 9'h001;
    repeat (2) @(negedge clk);
    rd(1, 8'h01, "R9 line 3 to bit 0");
    isa_req = 9'h1FF;
    repeat (2) @(negedge clk);
    rd(1, 8'hFF, "R9 all lines");
    wr(5, 1);
    check("R8 external enabled", int'(irq_lvl2), 1);
    isa_req = '0;
    repeat (2) @(negedge clk);
    check("R8 external released", int'(irq_lvl2), 0);
    wr(5, 0);

    // mixed traffic: clears land on ticks now and then (R5)
    wr(2, 1);
    wr(3, 1);
    wr(4, 1);
    for (int i = 0; i < 3000; i++) begin
      if (i % 7 == 0) wr(8, 0);
      else if (i % 333 == 0) wr(7, 0);
      else if (i % 11 == 0) rd(0, model_read(0), "R10 R5 status during traffic");
      else @(negedge clk);
    end
    finish_run();
  end

endmodule